// File: doc/BRIEF.md
# Multiplier with Product Register

This block performs 16x16 multiplication and keeps the 32-bit result in a product register. A command strobe comes with a 3-bit opcode and a 16-bit data word. One opcode loads a 16-bit temporary operand register from the data word. The multiply opcodes form the product of the temporary register and the data word, either signed or unsigned. The square opcodes multiply the data word by itself.

The product register can only be read through a scaling shifter that a 2-bit shift-mode input controls. The scaled value is offered whole on an arithmetic-unit port, and also split into an upper and a lower 16-bit half for storing. A separate opcode writes the upper half of the product register directly.

Because every read is scaled, a saved product is put back with a fixed sequence:
1. Load the saved lower half into the temporary register.
2. Issue an unsigned multiply by one.
3. Issue the upper-half load.

The square opcodes also raise a one-cycle request toward the accumulator, with a flag that says whether the square is to be added or subtracted.

Top module: `mulpr_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the product register, the temporary register and `acc_req` are cleared, so all product outputs read zero.
- R2: Opcode 3'd1 (load temporary) copies `cmd_data` into the temporary register at the strobe edge and leaves the product register unchanged.
- R3: Opcode 3'd2 (signed multiply) loads the two's-complement product of the temporary register and `cmd_data` into the product register at the clock edge that samples the strobe.
- R4: Opcode 3'd3 (unsigned multiply) loads the unsigned product of the temporary register and `cmd_data`.
- R5: Opcodes 3'd4 and 3'd5 load the signed square of `cmd_data` and leave the temporary register unchanged. In the following cycle `acc_req` is 1, and `acc_sub` is 0 for 3'd4 or 1 for 3'd5. After any other command, or after an idle cycle, `acc_req` is 0.
- R6: A multiply with `cmd_data` equal to zero clears the product register.
- R7: Opcode 3'd6 (load high) writes `cmd_data` into product bits 31:16 and keeps bits 15:0.
- R8: `alu_prod` is the product register scaled by `pshift_mode`: 2'b00 gives no shift, 2'b01 a left shift by 1, 2'b10 a left shift by 4, and 2'b11 an arithmetic right shift by 6. Bits shifted out are lost, and a left shift fills with zeros.
- R9: `prod_hi` is bits 31:16 and `prod_lo` is bits 15:0 of the scaled value. Reading, or changing `pshift_mode`, never alters the product register.
- R10: Opcodes 3'd0 and 3'd7, and cycles with `cmd_valid` low, leave both registers unchanged.
- R11: Loading a saved lower half L with opcode 3'd1, then issuing opcode 3'd3 with data 1, then opcode 3'd6 with a saved upper half H, leaves the product register equal to {H, L}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command opcode |
| cmd_data | input | 16 | Data operand |
| pshift_mode | input | 2 | Product scaling mode |
| prod_hi | output | 16 | Upper half of the scaled product |
| prod_lo | output | 16 | Lower half of the scaled product |
| alu_prod | output | 32 | Full scaled product toward the arithmetic unit |
| acc_req | output | 1 | Square result is ready for the accumulator |
| acc_sub | output | 1 | Square result is to be subtracted (1) or added (0) |

## Verification
The product register can never be observed unscaled unless the shift mode is zero. The hardest case is therefore a register whose contents differ from what any readout shows: for example, a product whose upper bits are lost under a left shift, or whose lower bits are lost under the right shift.

The stimulus reaches this case in two steps:
- It leaves such a product in the register under a non-zero shift mode.
- It then reads the same register again with the mode set to zero and runs the restore sequence on it.

This exposes any readout that had written the scaled value back.

The signed limits 0x8000 and 0x7FFF are multiplied and squared. These show sign-extension faults that a model would otherwise hide between the signed and the unsigned paths.

// File: rtl/mulpr_pkg.sv
package mulpr_pkg;

    parameter int unsigned OPW = 16;
    localparam int unsigned PW = 2 * OPW;
    localparam int unsigned SH_L1 = 1;
    localparam int unsigned SH_L4 = 4;
    localparam int unsigned SH_R6 = 6;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_LDT  = 3'd1,
        OP_MPY  = 3'd2,
        OP_MPYU = 3'd3,
        OP_SQA  = 3'd4,
        OP_SQS  = 3'd5,
        OP_LDH  = 3'd6,
        OP_RSV  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        PS_NONE = 2'b00,
        PS_L1   = 2'b01,
        PS_L4   = 2'b10,
        PS_R6   = 2'b11
    } pshift_e;

    typedef struct packed {
        logic [OPW-1:0] opa;
        logic [OPW-1:0] opb;
        logic           sgn;
        logic           load_p;
        logic           load_t;
        logic           load_h;
        logic           sq;
        logic           sq_sub;
    } mul_req_t;

    function automatic logic [PW-1:0] pscale(input logic [PW-1:0] p, input pshift_e m);
        logic [PW-1:0] r;
        case (m)
            PS_L1:   r = p << SH_L1;
            PS_L4:   r = p << SH_L4;
            PS_R6:   r = $unsigned($signed(p) >>> SH_R6);
            default: r = p;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mulpr_opsel.sv
module mulpr_opsel
    import mulpr_pkg::*;
#(
    parameter int unsigned W = OPW
) (
    input  logic           valid,
    input  op_e            op,
    input  logic [W-1:0]   data,
    input  logic [W-1:0]   treg,
    output mul_req_t       req
);
    always_comb begin
        req = '0;
        req.opa = treg;
        req.opb = data;
        if (valid) begin
            case (op)
                OP_LDT: req.load_t = 1'b1;
                OP_MPY: begin
                    req.load_p = 1'b1;
                    req.sgn    = 1'b1;
                end
                OP_MPYU: begin
                    req.load_p = 1'b1;
                    req.sgn    = 1'b0;
                end
                OP_SQA, OP_SQS: begin
                    req.opa    = data;
                    req.load_p = 1'b1;
                    req.sgn    = 1'b1;
                    req.sq     = 1'b1;
                    req.sq_sub = (op == OP_SQS);
                end
                OP_LDH:  req.load_h = 1'b1;
                default: req = req;
            endcase
        end
    end
endmodule

// File: rtl/mulpr_mult.sv
module mulpr_mult #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           sgn,
    output logic [2*W-1:0] p
);
    localparam int unsigned XW = W + 1;
    localparam int unsigned RW = 2 * XW;

    logic signed [XW-1:0] ax;
    logic signed [XW-1:0] bx;
    logic signed [RW-1:0] full;

    always_comb begin
        ax   = $signed({sgn & a[W-1], a});
        bx   = $signed({sgn & b[W-1], b});
        full = ax * bx;
        p    = full[2*W-1:0];
    end
endmodule

// File: rtl/mulpr_preg.sv
module mulpr_preg
    import mulpr_pkg::*;
#(
    parameter int unsigned W = OPW
) (
    input  logic           clk,
    input  logic           rst,
    input  mul_req_t       req,
    input  logic [2*W-1:0] prod,
    input  logic [W-1:0]   data,
    output logic [W-1:0]   treg,
    output logic [2*W-1:0] preg,
    output logic           acc_req,
    output logic           acc_sub
);
    localparam int unsigned P = 2 * W;

    always_ff @(posedge clk) begin
        if (rst) begin
            treg    <= '0;
            preg    <= '0;
            acc_req <= 1'b0;
            acc_sub <= 1'b0;
        end else begin
            if (req.load_t)
                treg <= data;
            if (req.load_p)
                preg <= prod;
            else if (req.load_h)
                preg[P-1:W] <= data;
            acc_req <= req.sq;
            acc_sub <= req.sq & req.sq_sub;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !(req.load_p || req.load_h) |=> $stable(preg)); // R10

    AST_LDH_KEEP_LO: assert property (@(posedge clk) disable iff (rst)
        req.load_h |=> preg[W-1:0] == $past(preg[W-1:0])); // R7

    AST_LDH_SET_HI: assert property (@(posedge clk) disable iff (rst)
        req.load_h |=> preg[P-1:W] == $past(data)); // R7

    AST_SQ_NONNEG: assert property (@(posedge clk) disable iff (rst)
        req.sq |=> !preg[P-1]); // R5

    AST_SQ_KEEP_T: assert property (@(posedge clk) disable iff (rst)
        req.sq |=> $stable(treg)); // R5

    AST_ACC_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        acc_req |-> $past(req.sq)); // R5

endmodule

// File: rtl/mulpr_pscale.sv
module mulpr_pscale
    import mulpr_pkg::*;
#(
    parameter int unsigned W = OPW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [2*W-1:0] preg,
    input  pshift_e        mode,
    output logic [2*W-1:0] scaled,
    output logic [W-1:0]   hi,
    output logic [W-1:0]   lo
);
    localparam int unsigned P = 2 * W;

    always_comb begin
        scaled = pscale(preg, mode);
        hi     = scaled[P-1:W];
        lo     = scaled[W-1:0];
    end

    AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
        (preg == '0) |-> (scaled == '0)); // R8

    AST_L1_LSB_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (mode == PS_L1) |-> !scaled[0]); // R8

    AST_R6_SIGN_KEEP: assert property (@(posedge clk) disable iff (rst)
        (mode == PS_R6) |-> scaled[P-1] == preg[P-1]); // R8

endmodule

// File: rtl/mulpr_unit.sv
module mulpr_unit
    import mulpr_pkg::*;
#(
    parameter int unsigned W = OPW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cmd_valid,
    input  logic [2:0]     cmd_op,
    input  logic [W-1:0]   cmd_data,
    input  logic [1:0]     pshift_mode,
    output logic [W-1:0]   prod_hi,
    output logic [W-1:0]   prod_lo,
    output logic [2*W-1:0] alu_prod,
    output logic           acc_req,
    output logic           acc_sub
);
    localparam int unsigned P = 2 * W;

    mul_req_t       req;
    logic [W-1:0]   treg;
    logic [P-1:0]   preg;
    logic [P-1:0]   prod;

    mulpr_opsel #(.W(W)) u_opsel (
        .valid (cmd_valid),
        .op    (op_e'(cmd_op)),
        .data  (cmd_data),
        .treg  (treg),
        .req   (req)
    );

    mulpr_mult #(.W(W)) u_mult (
        .a   (req.opa),
        .b   (req.opb),
        .sgn (req.sgn),
        .p   (prod)
    );

    mulpr_preg #(.W(W)) u_preg (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .prod    (prod),
        .data    (cmd_data),
        .treg    (treg),
        .preg    (preg),
        .acc_req (acc_req),
        .acc_sub (acc_sub)
    );

    mulpr_pscale #(.W(W)) u_pscale (
        .clk    (clk),
        .rst    (rst),
        .preg   (preg),
        .mode   (pshift_e'(pshift_mode)),
        .scaled (alu_prod),
        .hi     (prod_hi),
        .lo     (prod_lo)
    );

    AST_ZERO_MULT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && (cmd_op == 3'd2 || cmd_op == 3'd3) && cmd_data == '0)
        |=> (preg == '0)); // R6

    AST_ACC_SUB_QUAL: assert property (@(posedge clk) disable iff (rst)
        acc_sub |-> acc_req); // R5

endmodule

// File: tb/mulpr_unit_test.sv
`timescale 1ns/1ps
module mulpr_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [15:0] cmd_data = 16'd0;
    logic [1:0]  pshift_mode = 2'b00;
    logic [15:0] prod_hi, prod_lo;
    logic [31:0] alu_prod;
    logic        acc_req, acc_sub;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] m_t;
    logic [31:0] m_p;

    always #2.5 clk = ~clk;

    mulpr_unit uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .pshift_mode(pshift_mode), .prod_hi(prod_hi),
        .prod_lo(prod_lo), .alu_prod(alu_prod), .acc_req(acc_req), .acc_sub(acc_sub)
    );

    // vector: {op[2:0], pm[1:0], data[15:0]}
    localparam int NV = 18;
    localparam logic [20:0] VEC [NV] = '{
        {3'd1, 2'b00, 16'h1234},
        {3'd2, 2'b00, 16'h0010},
        {3'd2, 2'b01, 16'hFFFF},
        {3'd1, 2'b00, 16'hFFFF},
        {3'd3, 2'b00, 16'h0002},
        {3'd2, 2'b10, 16'h0002},
        {3'd4, 2'b11, 16'h8000},
        {3'd5, 2'b00, 16'h7FFF},
        {3'd6, 2'b01, 16'hABCD},
        {3'd0, 2'b00, 16'h5555},
        {3'd7, 2'b10, 16'hAAAA},
        {3'd2, 2'b00, 16'h0000},
        {3'd1, 2'b00, 16'h8000},
        {3'd2, 2'b11, 16'h8000},
        {3'd3, 2'b00, 16'h8000},
        {3'd5, 2'b10, 16'hFFFE},
        {3'd6, 2'b11, 16'h8001},
        {3'd3, 2'b00, 16'h0000}
    };

    function automatic logic [31:0] mdl_mul(input logic [15:0] a, input logic [15:0] b, input logic s);
        logic signed [31:0] r;
        if (s) r = $signed({{16{a[15]}}, a}) * $signed({{16{b[15]}}, b});
        else   r = $signed({16'd0, a} * {16'd0, b});
        return r;
    endfunction

    function automatic logic [31:0] mdl_scale(input logic [31:0] p, input logic [1:0] m);
        case (m)
            2'b01:   return {p[30:0], 1'b0};
            2'b10:   return {p[27:0], 4'b0};
            2'b11:   return {{6{p[31]}}, p[31:6]};
            default: return p;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] op, input logic [15:0] d);
        if ((op == 3'd2 || op == 3'd3) && d == 16'd0) return "R6";
        case (op)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4, 3'd5: return "R5";
            3'd6: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [15:0] d, input logic [1:0] pm);
        @(negedge clk);
        cmd_valid   = 1'b1;
        cmd_op      = op;
        cmd_data    = d;
        pshift_mode = pm;
        @(negedge clk);
        cmd_valid = 1'b0;
        case (op)
            3'd1: m_t = d;
            3'd2: m_p = mdl_mul(m_t, d, 1'b1);
            3'd3: m_p = mdl_mul(m_t, d, 1'b0);
            3'd4, 3'd5: m_p = mdl_mul(d, d, 1'b1);
            3'd6: m_p = {d, m_p[15:0]};
            default: m_p = m_p;
        endcase
    endtask

    task automatic check_out(input string req);
        chk(req, "alu_prod", alu_prod, mdl_scale(m_p, pshift_mode));
        chk("R9", "prod_hi", {16'd0, prod_hi}, {16'd0, mdl_scale(m_p, pshift_mode) >> 16});
        chk("R9", "prod_lo", {16'd0, prod_lo}, {16'd0, mdl_scale(m_p, pshift_mode) & 32'hFFFF});
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] saved;
        m_t = 16'd0;
        m_p = 32'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "alu_prod", alu_prod, 32'd0);
        chk("R1", "acc_req", {31'd0, acc_req}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [2:0]  op;
            logic [1:0]  pm;
            logic [15:0] d;
            {op, pm, d} = VEC[i];
            issue(op, d, pm);
            check_out(tag_of(op, d));
            // R5 accumulator request flags
            chk("R5", "acc_req", {31'd0, acc_req}, {31'd0, (op == 3'd4 || op == 3'd5)});
            chk("R5", "acc_sub", {31'd0, acc_sub}, {31'd0, (op == 3'd5)});
            // R8 every mode on the same product, R9 reading leaves it intact
            for (int m = 0; m < 4; m++) begin
                pshift_mode = m[1:0];
                #1;
                chk("R8", "alu_prod mode", alu_prod, mdl_scale(m_p, m[1:0]));
            end
        end

        // literal corner values
        issue(3'd4, 16'h8000, 2'b00);
        chk("R5", "square 8000", alu_prod, 32'h40000000);
        pshift_mode = 2'b11; #1;
        chk("R8", "r6 of 40000000", alu_prod, 32'h01000000);
        issue(3'd1, 16'hFFFF, 2'b00);
        issue(3'd2, 16'h0002, 2'b00);
        chk("R3", "-1*2", alu_prod, 32'hFFFFFFFE);
        issue(3'd3, 16'h0002, 2'b00);
        chk("R4", "ffff*2 unsigned", alu_prod, 32'h0001FFFE);
        @(negedge clk);
        chk("R5", "acc_req idle", {31'd0, acc_req}, 32'd0);

        // R9 shifted read leaves product intact, then R11 restore
        issue(3'd1, 16'hC3A5, 2'b00);
        issue(3'd2, 16'h7B1F, 2'b01);
        pshift_mode = 2'b00; #1;
        saved = alu_prod;
        chk("R9", "product after shifted read", alu_prod, m_p);
        issue(3'd2, 16'h0000, 2'b00);
        chk("R6", "cleared", alu_prod, 32'd0);
        issue(3'd1, saved[15:0], 2'b00);
        issue(3'd3, 16'h0001, 2'b00);
        issue(3'd6, saved[31:16], 2'b00);
        chk("R11", "restored", alu_prod, saved);

        // R10 invalid strobe with multiply opcode changes nothing
        @(negedge clk);
        cmd_op = 3'd2; cmd_data = 16'h0000; cmd_valid = 1'b0;
        @(negedge clk);
        chk("R10", "strobe low", alu_prod, saved);

        // R1 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_p = 32'd0; m_t = 16'd0;
        chk("R1", "reset product", alu_prod, 32'd0);
        issue(3'd2, 16'h1234, 2'b00);
        chk("R1", "reset treg", alu_prod, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule